// File: doc/BRIEF.md
# Two-Target Interrupt Priority Distributor

This block collects interrupt requests and steers them to two processor targets. Each target owns a private bank of IDs 0 to 31. IDs 0 to 15 are software-raised and IDs 27 to 31 come from private level inputs. IDs 32 to 92 form a pool of shared level inputs that both targets can see. Every source keeps its own enable, 8-bit priority, security group and active state. Shared sources also keep a route mask. A duplicated priority picker chooses one winner per target in the same cycle. The winner is shown on either the fast or the normal request output of that target.

Software programs the block through a single-cycle write port. A target takes its winner with a one-cycle acknowledge pulse. The ID comes back one cycle later, and the interrupt moves from pending to active. A later end-of-interrupt carrying the same ID retires it. Private and shared inputs pass through a two-flop synchronizer and count as pending while the synchronized level is high and the source is not active.

Top module: `irq_distributor`

## Requirements
- R1: After reset both request outputs of both targets are low, and an acknowledge returns ID 1023.
- R2: Write commands on `wr_cmd_i` are coded as follows. 0 sets the enable from data bit 0. 1 sets the priority. 2 sets the group (data bit 0 = 1 means secure). 3 sets the route of a shared ID (data bit t selects target t). 4 sets the priority mask of target `wr_tgt_i`. 5 sets the fast-enable of target `wr_tgt_i` from data bit 0. 6 raises software ID `wr_id_i` on every target whose bit is set in the data. Writes to IDs below 32 address the bank of `wr_tgt_i`. A raised, enabled software ID is signalled and its ID is returned on acknowledge.
- R3: Among the eligible interrupts of a target, the one with the numerically lowest priority value wins.
- R4: When priorities are equal, the lower ID wins.
- R5: An interrupt is signalled only if its priority is strictly below the target's priority mask. Equal is not enough.
- R6: IDs 0 to 31 are banked. A private input or enable of one target never causes a request on the other.
- R7: A shared ID reaches only the targets set in its route mask, and it can reach both at once.
- R8: A secure winner drives the fast output (and not the normal one) when that target's fast-enable is set. Otherwise every winner drives the normal output, and the fast output is never high while fast-enable is clear.
- R9: An acknowledge returns the winner one cycle later and makes it active. An active ID is not signalled again until an end-of-interrupt with that same ID arrives. An end-of-interrupt with a different ID has no effect.
- R10: An acknowledge with no eligible interrupt returns 1023 and leaves all pending state unchanged.
- R11: A shared input change reaches the request outputs after exactly two clock edges.
- R12: If both targets acknowledge the same shared ID in one cycle, target 0 receives it and target 1 receives 1023. The ID then stays off both targets until it is retired.
- R13: A disabled source is not signalled. A level source that drops before it is acknowledged stops being signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_cmd_i | input | 3 | Write command code (see R2) |
| wr_tgt_i | input | 1 | Target whose bank, mask or control is written |
| wr_id_i | input | 10 | Interrupt ID addressed by the write |
| wr_data_i | input | 8 | Write data |
| ppi_i | input | 2x5 | Private level inputs per target, IDs 27 to 31 |
| spi_i | input | 61 | Shared level inputs, IDs 32 to 92 |
| ack_i | input | 2 | Acknowledge pulse per target |
| ack_id_o | output | 2x10 | Returned ID per target |
| ack_vld_o | output | 2 | Returned ID valid, one cycle after acknowledge |
| eoi_i | input | 2 | End-of-interrupt pulse per target |
| eoi_id_i | input | 2x10 | ID being retired per target |
| fiq_o | output | 2 | Fast request per target |
| irq_o | output | 2 | Normal request per target |

## Verification
The hardest case to reach is a collision where both targets try to take the same shared ID. It needs one input routed to both targets and unmasked on each, with the two acknowledges landing in the same cycle. The bench routes a single shared line to both targets and waits out the synchronizer. It checks that both targets show a request, then drives both acknowledges from one task in the same cycle. It then checks that only target 0 got the ID and that it has left both targets. Active-state masking is reached in a similar way: the same software ID is raised again while still active, then retired first with a wrong ID and then with the right one.

// File: rtl/irqd_pkg.sv
// Shared constants and command codes for the two-target interrupt distributor.
// Assumes a fixed ID layout: private bank 0..31, shared pool from 32 upward.
package irqd_pkg;
    localparam int BANK_N   = 32;   // private IDs per target
    localparam int SGI_N    = 16;   // software-raised IDs 0..15
    localparam int PPI_BASE = 27;   // first private input ID
    localparam int PPI_N    = 5;    // private inputs 27..31
    localparam int IDW      = 10;   // width of returned IDs
    localparam logic [IDW-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [2:0] {
        CMD_ENABLE = 3'd0,
        CMD_PRIO   = 3'd1,
        CMD_GROUP  = 3'd2,
        CMD_ROUTE  = 3'd3,
        CMD_PMASK  = 3'd4,
        CMD_CTRL   = 3'd5,
        CMD_SGI    = 3'd6
    } cmd_e;
endpackage

// File: rtl/irqd_sync.sv
// Two-flop synchronizer for a vector of level inputs.
// Assumes each bit is an independent level; no bus coherence is implied.
module irqd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift each level through two flops into the local domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/irqd_pick.sv
// Combinational priority picker: lowest priority value wins, lowest index on ties.
// Assumes ok_i already folds in pending, enable, active, route and mask.
module irqd_pick #(
    parameter int N  = 93,
    parameter int PW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         ok_i,
    input  logic [N-1:0][PW-1:0] pri_i,
    input  logic [N-1:0]         sec_i,
    output logic                 found_o,
    output logic [IW-1:0]        id_o,
    output logic                 sec_o
);
    logic [PW-1:0] best;

    // Scan upward; strict compare keeps the earliest index among equals.
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        sec_o   = 1'b0;
        best    = '1;
        for (int i = 0; i < N; i++) begin
            if (ok_i[i] && (!found_o || (pri_i[i] < best))) begin
                found_o = 1'b1;
                best    = pri_i[i];
                id_o    = IW'(i);
                sec_o   = sec_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_distributor.sv
// Two-target interrupt distributor with banked private IDs and a shared pool.
// Holds per-source enable, priority, group, route and active state, picks one
// winner per target in parallel and serves acknowledge / end-of-interrupt.
// Assumes single-cycle pulses on ack_i / eoi_i and wr_en_i.
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_TGT = 2,
    parameter int SPI_N   = 61,
    parameter int PW      = 8,
    localparam int TW     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [2:0]                         wr_cmd_i,
    input  logic [TW-1:0]                      wr_tgt_i,
    input  logic [IDW-1:0]                     wr_id_i,
    input  logic [7:0]                         wr_data_i,
    input  logic [NUM_TGT-1:0][PPI_N-1:0]      ppi_i,
    input  logic [SPI_N-1:0]                   spi_i,
    input  logic [NUM_TGT-1:0]                 ack_i,
    output logic [NUM_TGT-1:0][IDW-1:0]        ack_id_o,
    output logic [NUM_TGT-1:0]                 ack_vld_o,
    input  logic [NUM_TGT-1:0]                 eoi_i,
    input  logic [NUM_TGT-1:0][IDW-1:0]        eoi_id_i,
    output logic [NUM_TGT-1:0]                 fiq_o,
    output logic [NUM_TGT-1:0]                 irq_o
);
    localparam int NUM_ID = BANK_N + SPI_N;
    localparam int SELW   = $clog2(NUM_ID);
    localparam int BKW    = $clog2(BANK_N);
    localparam int SGW    = $clog2(SGI_N);
    localparam int SHW    = $clog2(SPI_N);

    // Private bank state, one copy per target.
    logic [NUM_TGT-1:0][BANK_N-1:0]         pv_en, pv_sec, pv_act;
    logic [NUM_TGT-1:0][BANK_N-1:0][PW-1:0] pv_pri;
    logic [NUM_TGT-1:0][SGI_N-1:0]          sgi_pend;
    // Shared pool state.
    logic [SPI_N-1:0]                       sh_en, sh_sec, sh_act;
    logic [SPI_N-1:0][PW-1:0]               sh_pri;
    logic [SPI_N-1:0][NUM_TGT-1:0]          sh_route;
    logic [SPI_N-1:0][TW-1:0]               sh_own;
    // Per-target controls.
    logic [NUM_TGT-1:0][PW-1:0]             pmask;
    logic [NUM_TGT-1:0]                     fast_en;

    logic [NUM_TGT-1:0][PPI_N-1:0]          ppi_s;
    logic [SPI_N-1:0]                       spi_s;
    logic [NUM_TGT-1:0]                     found, win_sec, grant;
    logic [NUM_TGT-1:0][IDW-1:0]            win_id;

    function automatic logic priv_impl(input logic [IDW-1:0] id);
        return (id < IDW'(SGI_N)) ||
               ((id >= IDW'(PPI_BASE)) && (id < IDW'(BANK_N)));
    endfunction

    function automatic logic is_shared(input logic [IDW-1:0] id);
        return (id >= IDW'(BANK_N)) && (id < IDW'(NUM_ID));
    endfunction

    function automatic logic [SHW-1:0] sh_idx(input logic [IDW-1:0] id);
        logic [IDW-1:0] d;
        d = id - IDW'(BANK_N);
        return d[SHW-1:0];
    endfunction

    irqd_sync #(.W(NUM_TGT*PPI_N)) u_ppi_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ppi_i), .q_o(ppi_s)
    );

    irqd_sync #(.W(SPI_N)) u_spi_sync (
        .clk(clk), .rst_n(rst_n), .d_i(spi_i), .q_o(spi_s)
    );

    // One candidate builder and picker per target, running in parallel.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        logic [NUM_ID-1:0]         pend, en, act, ok, sec;
        logic [NUM_ID-1:0][PW-1:0] pri;
        logic [SELW-1:0]           sel_id;

        // Flatten banked and shared state into this target's view.
        always_comb begin
            pend = '0;
            pend[SGI_N-1:0]        = sgi_pend[g];
            pend[PPI_BASE +: PPI_N] = ppi_s[g];
            pend[BANK_N +: SPI_N]  = spi_s;
            en  = '0;
            en[BANK_N-1:0] = pv_en[g];
            act = '0;
            act[BANK_N-1:0] = pv_act[g];
            act[BANK_N +: SPI_N] = sh_act;
            sec = '0;
            sec[BANK_N-1:0] = pv_sec[g];
            sec[BANK_N +: SPI_N] = sh_sec;
            for (int i = 0; i < BANK_N; i++) pri[i] = pv_pri[g][i];
            for (int s = 0; s < SPI_N; s++) begin
                pri[BANK_N+s] = sh_pri[s];
                en[BANK_N+s]  = sh_en[s] & sh_route[s][g];
            end
            for (int i = 0; i < NUM_ID; i++)
                ok[i] = pend[i] & en[i] & ~act[i] & (pri[i] < pmask[g]);
        end

        irqd_pick #(.N(NUM_ID), .PW(PW)) u_pick (
            .ok_i(ok), .pri_i(pri), .sec_i(sec),
            .found_o(found[g]), .id_o(sel_id), .sec_o(win_sec[g])
        );

        assign win_id[g] = IDW'(sel_id);
        assign fiq_o[g]  = found[g] & win_sec[g] & fast_en[g];
        assign irq_o[g]  = found[g] & ~(win_sec[g] & fast_en[g]);
    end

    // Grant acknowledges; a shared ID taken by a lower target blocks higher ones.
    always_comb begin
        for (int t = 0; t < NUM_TGT; t++) begin
            grant[t] = ack_i[t] & found[t];
            for (int u = 0; u < t; u++) begin
                if (ack_i[u] && found[u] && (win_id[u] == win_id[t]) &&
                    is_shared(win_id[t]))
                    grant[t] = 1'b0;
            end
        end
    end

    // Configuration, pending, active and ownership state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_en    <= '0;
            pv_sec   <= '0;
            pv_act   <= '0;
            pv_pri   <= '0;
            sgi_pend <= '0;
            sh_en    <= '0;
            sh_sec   <= '0;
            sh_act   <= '0;
            sh_pri   <= '0;
            sh_route <= '0;
            sh_own   <= '0;
            pmask    <= '0;
            fast_en  <= '0;
        end else begin
            for (int t = 0; t < NUM_TGT; t++) begin
                if (eoi_i[t]) begin
                    if (priv_impl(eoi_id_i[t]))
                        pv_act[t][eoi_id_i[t][BKW-1:0]] <= 1'b0;
                    else if (is_shared(eoi_id_i[t]) &&
                             (sh_own[sh_idx(eoi_id_i[t])] == TW'(t)))
                        sh_act[sh_idx(eoi_id_i[t])] <= 1'b0;
                end
                if (grant[t]) begin
                    if (win_id[t] < IDW'(BANK_N)) begin
                        pv_act[t][win_id[t][BKW-1:0]] <= 1'b1;
                        if (win_id[t] < IDW'(SGI_N))
                            sgi_pend[t][win_id[t][SGW-1:0]] <= 1'b0;
                    end else begin
                        sh_act[sh_idx(win_id[t])] <= 1'b1;
                        sh_own[sh_idx(win_id[t])] <= TW'(t);
                    end
                end
            end
            if (wr_en_i) begin
                case (cmd_e'(wr_cmd_i))
                    CMD_ENABLE: begin
                        if (priv_impl(wr_id_i))
                            pv_en[wr_tgt_i][wr_id_i[BKW-1:0]] <= wr_data_i[0];
                        else if (is_shared(wr_id_i))
                            sh_en[sh_idx(wr_id_i)] <= wr_data_i[0];
                    end
                    CMD_PRIO: begin
                        if (priv_impl(wr_id_i))
                            pv_pri[wr_tgt_i][wr_id_i[BKW-1:0]] <= wr_data_i[PW-1:0];
                        else if (is_shared(wr_id_i))
                            sh_pri[sh_idx(wr_id_i)] <= wr_data_i[PW-1:0];
                    end
                    CMD_GROUP: begin
                        if (priv_impl(wr_id_i))
                            pv_sec[wr_tgt_i][wr_id_i[BKW-1:0]] <= wr_data_i[0];
                        else if (is_shared(wr_id_i))
                            sh_sec[sh_idx(wr_id_i)] <= wr_data_i[0];
                    end
                    CMD_ROUTE: begin
                        if (is_shared(wr_id_i))
                            sh_route[sh_idx(wr_id_i)] <= wr_data_i[NUM_TGT-1:0];
                    end
                    CMD_PMASK: pmask[wr_tgt_i]   <= wr_data_i[PW-1:0];
                    CMD_CTRL:  fast_en[wr_tgt_i] <= wr_data_i[0];
                    CMD_SGI: begin
                        if (wr_id_i < IDW'(SGI_N))
                            for (int t = 0; t < NUM_TGT; t++)
                                if (wr_data_i[t]) sgi_pend[t][wr_id_i[SGW-1:0]] <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register the returned ID one cycle after each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld_o <= '0;
            ack_id_o  <= '0;
        end else begin
            for (int t = 0; t < NUM_TGT; t++) begin
                ack_vld_o[t] <= ack_i[t];
                if (ack_i[t]) ack_id_o[t] <= grant[t] ? win_id[t] : SPURIOUS_ID;
            end
        end
    end

    for (genvar a = 0; a < NUM_TGT; a++) begin : g_ast
        AST_ACK_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ack_vld_o[a] |-> $past(ack_i[a])); // R9
        AST_REAL_ID_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vld_o[a] && ack_id_o[a] != SPURIOUS_ID) |-> $past(fiq_o[a] || irq_o[a])); // R9
        AST_IDLE_GIVES_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vld_o[a] && $past(!(fiq_o[a] || irq_o[a]))) |-> ack_id_o[a] == SPURIOUS_ID); // R10
        AST_FAST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_o[a] |-> fast_en[a]); // R8
    end

    if (NUM_TGT > 1) begin : g_ast_pair
        AST_SHARED_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            !(ack_vld_o[0] && ack_vld_o[1] && ack_id_o[0] == ack_id_o[1] &&
              ack_id_o[0] != SPURIOUS_ID && ack_id_o[0] >= IDW'(BANK_N))); // R12
    end
endmodule

// File: tb/irq_distributor_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: acknowledge tasks queue expected IDs, a monitor checks them.
module irq_distributor_tb_top;
    import irqd_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_cmd = '0;
    logic [0:0] wr_tgt = '0;
    logic [9:0] wr_id = '0;
    logic [7:0] wr_data = '0;
    logic [1:0][4:0] ppi = '0;
    logic [60:0] spi = '0;
    logic [1:0] ack = '0;
    logic [1:0][9:0] ack_id;
    logic [1:0] ack_vld;
    logic [1:0] eoi = '0;
    logic [1:0][9:0] eoi_id = '0;
    logic [1:0] fiq, irq;

    int checks = 0;
    int fails = 0;
    int q0_id[$];
    int q1_id[$];
    string q0_req[$];
    string q1_req[$];

    always #4 clk = ~clk;

    irq_distributor dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_cmd_i(wr_cmd), .wr_tgt_i(wr_tgt),
        .wr_id_i(wr_id), .wr_data_i(wr_data),
        .ppi_i(ppi), .spi_i(spi),
        .ack_i(ack), .ack_id_o(ack_id), .ack_vld_o(ack_vld),
        .eoi_i(eoi), .eoi_id_i(eoi_id),
        .fiq_o(fiq), .irq_o(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input cmd_e c, input int t, input int id, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c; wr_tgt = 1'(t); wr_id = 10'(id); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int t, input int id, input string req);
        if (t == 0) begin q0_id.push_back(id); q0_req.push_back(req); end
        else        begin q1_id.push_back(id); q1_req.push_back(req); end
    endtask

    task automatic do_ack(input int t, input int exp, input string req);
        push(t, exp, req);
        @(negedge clk); ack[t] = 1'b1;
        @(negedge clk); ack[t] = 1'b0;
    endtask

    task automatic do_ack_both(input int e0, input int e1, input string req);
        push(0, e0, req); push(1, e1, req);
        @(negedge clk); ack = 2'b11;
        @(negedge clk); ack = 2'b00;
    endtask

    task automatic do_eoi(input int t, input int id);
        @(negedge clk); eoi[t] = 1'b1; eoi_id[t] = 10'(id);
        @(negedge clk); eoi[t] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the expected ID whenever the design returns one.
    always @(negedge clk) begin
        if (rst_n && ack_vld[0]) begin
            checks++;
            if (q0_id.size() == 0) begin
                fails++; $display("FAIL R9 target0 actual=%0d expected=none", ack_id[0]);
            end else begin
                int e; string r;
                e = q0_id.pop_front(); r = q0_req.pop_front();
                if (int'(ack_id[0]) != e) begin
                    fails++; $display("FAIL %s target0 actual=%0d expected=%0d", r, ack_id[0], e);
                end
            end
        end
        if (rst_n && ack_vld[1]) begin
            checks++;
            if (q1_id.size() == 0) begin
                fails++; $display("FAIL R9 target1 actual=%0d expected=none", ack_id[1]);
            end else begin
                int e; string r;
                e = q1_id.pop_front(); r = q1_req.pop_front();
                if (int'(ack_id[1]) != e) begin
                    fails++; $display("FAIL %s target1 actual=%0d expected=%0d", r, ack_id[1], e);
                end
            end
        end
    end

    initial begin
        #(8ns * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: quiet after reset, spurious acknowledge.
        chk("R1 fiq", int'(fiq), 0);
        chk("R1 irq", int'(irq), 0);
        do_ack(0, 1023, "R1");
        idle(1);

        wr(CMD_PMASK, 0, 0, 8'hFF);
        wr(CMD_PMASK, 1, 0, 8'hFF);

        // R2 / R6: software ID 3 enabled only in bank of target 0, raised on both.
        wr(CMD_PRIO, 0, 3, 8'h40);
        wr(CMD_ENABLE, 0, 3, 1);
        wr(CMD_SGI, 0, 3, 2'b11);
        chk("R2 irq0", int'(irq[0]), 1);
        chk("R6 irq1 bank disabled", int'(irq[1]), 0);
        do_ack(0, 3, "R2");
        chk("R9 irq0 after ack", int'(irq[0]), 0);
        wr(CMD_SGI, 0, 3, 2'b01);
        chk("R9 active blocks", int'(irq[0]), 0);
        do_eoi(0, 5);
        chk("R9 wrong eoi ignored", int'(irq[0]), 0);
        do_eoi(0, 3);
        chk("R9 eoi re-arms", int'(irq[0]), 1);
        do_ack(0, 3, "R9");
        do_eoi(0, 3);

        // R3: lower priority value wins.
        wr(CMD_PRIO, 0, 1, 8'h80);
        wr(CMD_PRIO, 0, 2, 8'h20);
        wr(CMD_ENABLE, 0, 1, 1);
        wr(CMD_ENABLE, 0, 2, 1);
        wr(CMD_SGI, 0, 1, 2'b01);
        wr(CMD_SGI, 0, 2, 2'b01);
        do_ack(0, 2, "R3");
        do_ack(0, 1, "R3");
        do_eoi(0, 2);
        do_eoi(0, 1);

        // R4: tie goes to lower ID.
        wr(CMD_PRIO, 0, 4, 8'h30);
        wr(CMD_PRIO, 0, 5, 8'h30);
        wr(CMD_ENABLE, 0, 4, 1);
        wr(CMD_ENABLE, 0, 5, 1);
        wr(CMD_SGI, 0, 5, 2'b01);
        wr(CMD_SGI, 0, 4, 2'b01);
        do_ack(0, 4, "R4");
        do_ack(0, 5, "R4");
        do_eoi(0, 4);
        do_eoi(0, 5);

        // R5: mask equal to priority blocks, one above passes.
        wr(CMD_PMASK, 0, 0, 8'h30);
        wr(CMD_PRIO, 0, 6, 8'h30);
        wr(CMD_ENABLE, 0, 6, 1);
        wr(CMD_SGI, 0, 6, 2'b01);
        chk("R5 equal masked", int'(irq[0]), 0);
        wr(CMD_PMASK, 0, 0, 8'h31);
        chk("R5 below mask", int'(irq[0]), 1);
        do_ack(0, 6, "R5");
        do_eoi(0, 6);
        wr(CMD_PMASK, 0, 0, 8'hFF);

        // R6: private input 29 enabled only in bank of target 1.
        wr(CMD_PRIO, 1, 29, 8'h10);
        wr(CMD_ENABLE, 1, 29, 1);
        @(negedge clk); ppi[0][2] = 1'b1;
        idle(3);
        chk("R6 t0 input no effect t0", int'(irq[0]), 0);
        chk("R6 t0 input no effect t1", int'(irq[1]), 0);
        @(negedge clk); ppi[1][2] = 1'b1;
        idle(3);
        chk("R6 t1 input", int'(irq[1]), 1);
        do_ack(1, 29, "R6");
        @(negedge clk); ppi = '0;
        idle(3);
        do_eoi(1, 29);
        chk("R6 retired", int'(irq[1]), 0);

        // R11 / R7 / R12: shared ID 40.
        wr(CMD_PRIO, 0, 40, 8'h50);
        wr(CMD_ENABLE, 0, 40, 1);
        wr(CMD_ROUTE, 0, 40, 2'b01);
        @(negedge clk); spi[8] = 1'b1;
        @(negedge clk);
        chk("R11 one edge", int'(irq[0]), 0);
        @(negedge clk);
        chk("R11 two edges", int'(irq[0]), 1);
        chk("R7 not routed t1", int'(irq[1]), 0);
        wr(CMD_ROUTE, 0, 40, 2'b10);
        chk("R7 moved off t0", int'(irq[0]), 0);
        chk("R7 moved to t1", int'(irq[1]), 1);
        wr(CMD_ROUTE, 0, 40, 2'b11);
        chk("R7 both t0", int'(irq[0]), 1);
        chk("R7 both t1", int'(irq[1]), 1);
        do_ack_both(40, 1023, "R12");
        chk("R12 off t0", int'(irq[0]), 0);
        chk("R12 off t1", int'(irq[1]), 0);
        @(negedge clk); spi[8] = 1'b0;
        idle(3);
        do_eoi(0, 40);
        chk("R13 dropped level t0", int'(irq[0]), 0);
        chk("R13 dropped level t1", int'(irq[1]), 0);

        // R8: secure shared ID 41 on target 0.
        wr(CMD_PRIO, 0, 41, 8'h60);
        wr(CMD_GROUP, 0, 41, 1);
        wr(CMD_ROUTE, 0, 41, 2'b01);
        wr(CMD_ENABLE, 0, 41, 1);
        @(negedge clk); spi[9] = 1'b1;
        idle(3);
        chk("R8 no fast fiq", int'(fiq[0]), 0);
        chk("R8 no fast irq", int'(irq[0]), 1);
        wr(CMD_CTRL, 0, 0, 1);
        chk("R8 fast fiq", int'(fiq[0]), 1);
        chk("R8 fast irq", int'(irq[0]), 0);
        do_ack(0, 41, "R8");
        @(negedge clk); spi[9] = 1'b0;
        idle(3);
        do_eoi(0, 41);
        chk("R8 fiq retired", int'(fiq[0]), 0);

        // R13 / R10: disabled source is silent; spurious ack keeps it pending.
        wr(CMD_PRIO, 0, 7, 8'h10);
        wr(CMD_SGI, 0, 7, 2'b01);
        chk("R13 disabled", int'(irq[0]), 0);
        do_ack(0, 1023, "R10");
        wr(CMD_ENABLE, 0, 7, 1);
        chk("R10 pending kept", int'(irq[0]), 1);
        do_ack(0, 7, "R10");
        do_eoi(0, 7);
        idle(2);

        chk("R9 queue0 drained", q0_id.size(), 0);
        chk("R9 queue1 drained", q1_id.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule